// File: doc/BRIEF.md
# Buffered UART Transmit Engine

This block is the transmit half of a serial port. Characters enter through a one-cycle write strobe and wait in a four-entry holding buffer. When the shift stage is idle and the next baud tick arrives, the oldest character moves into a shift register. It then goes out on the serial pin as an 8N1 frame, least significant bit first, one bit per tick. The baud tick comes from a rate generator outside the block.

Status outputs report when the buffer can take no more characters, and when every queued and in-flight character has left the pin. A two-bit select picks the event that pulses the interrupt output. A break request makes the next frame a long run of zeros, and the request clears itself once that frame is sent. A polarity control, combined with an infrared-mode flag, sets the idle level of the line. Dropping the enable abandons the frame on the pin, empties the buffer, cancels any pending break and hands the pin to a general-purpose level.

Top module: `uart_tx_engine`

## Requirements
- R1: Under reset, buf_full is 0, shift_empty is 1, brk_pending is 0, irq is 0 and txd is 1.
- R2: The buffer holds four characters. buf_full is 1 exactly when four are held. A write while buf_full is 1 is dropped and never reaches the line.
- R3: A frame begins on a baud tick. It is one low start bit, then the eight data bits least significant first, then one high stop bit. Each bit lasts one baud-tick interval, and characters go out in write order.
- R4: shift_empty is 1 only when the shift stage is idle and the buffer is empty; it is 0 while a frame is on the line.
- R5: With irq_mode = 2'b00, irq pulses once for every character moved from the buffer into the shift stage.
- R6: With irq_mode = 2'b10, irq pulses only when such a move leaves the buffer empty.
- R7: With irq_mode = 2'b01, irq pulses when a frame's stop bit ends with the buffer empty and no break waiting.
- R8: With irq_mode = 2'b11, irq never pulses, and in every mode each pulse lasts exactly one clock cycle.
- R9: A brk_set pulse raises brk_pending. The next frame is sent as a start bit, then twelve zero bits, then a stop bit, ahead of characters already queued. brk_pending returns to 0 when that frame ends. A break frame does not count as a character move for R5 and R6.
- R10: The line polarity is idle_inv XOR ir_mode. When it is 0, the line idles high and bits go out true. When it is 1, the line idles low and every bit is inverted.
- R11: While tx_en is 0, txd follows gpio_level one cycle later. Clearing tx_en abandons the frame on the pin, empties the buffer and clears brk_pending. Writes and break requests made while disabled are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; low aborts and flushes |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_valid | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to queue |
| brk_set | input | 1 | Request a break frame |
| irq_mode | input | 2 | Interrupt event select |
| idle_inv | input | 1 | Idle level inversion |
| ir_mode | input | 1 | Infrared-mode flag, flips the sense of idle_inv |
| gpio_level | input | 1 | Pin level while disabled |
| buf_full | output | 1 | No further write is accepted |
| shift_empty | output | 1 | Buffer and shift stage both empty |
| brk_pending | output | 1 | Break requested and not yet completed |
| irq | output | 1 | One-cycle interrupt pulse |
| txd | output | 1 | Serial output pin |

## Verification
The bench decodes the pin at mid-bit. A design that shifts most significant bit first, drops the stop bit or misses a tick would therefore show as wrong bytes. A break that is shorter or longer than thirteen low bit-times, or that goes out after the queued character, shows as a wrong event in the decoded stream. Bursts written just after a tick separate the three interrupt modes, so a drain interrupt that fires on every move, or a completion interrupt that fires between queued frames, gives the wrong pulse count. The fifth write into a stalled full buffer, the abort in mid-frame with a break pending, and both polarity combinations catch an overwritten entry, a leftover character after re-enable, and an idle level with the wrong sense.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    IRQ_ON_LOAD  = 2'b00,
    IRQ_ON_DONE  = 2'b01,
    IRQ_ON_DRAIN = 2'b10,
    IRQ_NONE     = 2'b11
  } irq_sel_e;
endpackage

// File: rtl/tx_hold_fifo.sv
module tx_hold_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign rd_data = mem[rp];

  // storage has no reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R2: a push into a full buffer with no pop leaves it full, never wrapped
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == CW'(DEPTH)));

  // R11: a flush empties the buffer
  p_flush_empties_r11: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter #(
  parameter int DATA_W    = 8,
  parameter int BRK_ZEROS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              baud_tick,
  input  logic              start_data,
  input  logic              start_brk,
  input  logic [DATA_W-1:0] data,
  output logic              busy,
  output logic              brk_active,
  output logic              line_bit,
  output logic              done
);
  // a break frame is start + BRK_ZEROS zeros + stop; data frames fit inside it
  localparam int FRAME_W = BRK_ZEROS + 2;
  localparam int LW      = $clog2(FRAME_W + 1);
  localparam int PAD_W   = FRAME_W - DATA_W - 1;

  logic [FRAME_W-1:0] frame;
  logic [LW-1:0]      left;

  assign done     = busy & baud_tick & (left == LW'(1));
  assign line_bit = busy ? frame[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy       <= 1'b0;
      brk_active <= 1'b0;
      left       <= '0;
      frame      <= '1;
    end else if (start_brk) begin
      busy       <= 1'b1;
      brk_active <= 1'b1;
      left       <= LW'(FRAME_W);
      frame      <= {1'b1, {(FRAME_W-1){1'b0}}};
    end else if (start_data) begin
      busy       <= 1'b1;
      brk_active <= 1'b0;
      left       <= LW'(DATA_W + 2);
      frame      <= {{PAD_W{1'b1}}, data, 1'b0};
    end else if (busy && baud_tick) begin
      if (left == LW'(1)) begin
        busy       <= 1'b0;
        brk_active <= 1'b0;
      end else begin
        frame <= {1'b1, frame[FRAME_W-1:1]};
        left  <= left - LW'(1);
      end
    end
  end

  // R3: the bit that ends a frame is always the high stop bit
  p_stop_high_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> frame[0]);

  // R3: a new frame is only loaded into an idle shifter
  p_load_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (start_data || start_brk) |-> !busy);

  // R11: an abort leaves the shifter idle
  p_abort_idle_r11: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy);
endmodule

// File: rtl/tx_irq_gen.sv
module tx_irq_gen
  import uart_tx_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  irq_sel_e      mode,
  input  logic          popped,
  input  logic          pushed,
  input  logic [CW-1:0] count_now,
  input  logic          frame_done,
  input  logic          brk_waiting,
  output logic          irq
);
  logic fire;

  always_comb begin
    case (mode)
      IRQ_ON_LOAD:  fire = popped;
      IRQ_ON_DRAIN: fire = popped && (count_now == CW'(1)) && !pushed;
      IRQ_ON_DONE:  fire = frame_done && (count_now == '0) && !pushed && !brk_waiting;
      default:      fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= en & fire;
  end

  // R8: every pulse lasts one cycle
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R8: the reserved select produces no pulse
  p_rsvd_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (mode == IRQ_NONE) |=> !irq);
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 4,
  parameter int BRK_ZEROS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              brk_set,
  input  logic [1:0]        irq_mode,
  input  logic              idle_inv,
  input  logic              ir_mode,
  input  logic              gpio_level,
  output logic              buf_full,
  output logic              shift_empty,
  output logic              brk_pending,
  output logic              irq,
  output logic              txd
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] head;
  logic [CW-1:0]     count;
  logic              empty, full;
  logic              push, start_data, start_brk;
  logic              busy, brk_active, line_bit, done;
  logic              brk_q, txd_q, pol;
  irq_sel_e          mode_sel;

  assign mode_sel   = irq_sel_e'(irq_mode);
  assign pol        = idle_inv ^ ir_mode;
  assign push       = wr_valid & tx_en & ~full;
  assign start_brk  = tx_en & baud_tick & ~busy & brk_q;
  assign start_data = tx_en & baud_tick & ~busy & ~brk_q & ~empty;

  tx_hold_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .flush   (~tx_en),
    .push    (push),
    .wr_data (wr_data),
    .pop     (start_data),
    .rd_data (head),
    .count   (count),
    .full    (full),
    .empty   (empty)
  );

  tx_frame_shifter #(.DATA_W(DATA_W), .BRK_ZEROS(BRK_ZEROS)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .abort      (~tx_en),
    .baud_tick  (baud_tick),
    .start_data (start_data),
    .start_brk  (start_brk),
    .data       (head),
    .busy       (busy),
    .brk_active (brk_active),
    .line_bit   (line_bit),
    .done       (done)
  );

  tx_irq_gen #(.CW(CW)) u_irq (
    .clk         (clk),
    .rst         (rst),
    .en          (tx_en),
    .mode        (mode_sel),
    .popped      (start_data),
    .pushed      (push),
    .count_now   (count),
    .frame_done  (done),
    .brk_waiting (brk_q & ~brk_active),
    .irq         (irq)
  );

  // break request: set by software, cleared when its frame ends or on disable
  always_ff @(posedge clk) begin
    if (rst || !tx_en) brk_q <= 1'b0;
    else               brk_q <= (brk_q & ~(done & brk_active)) | brk_set;
  end

  always_ff @(posedge clk) begin
    if (rst)         txd_q <= 1'b1;
    else if (!tx_en) txd_q <= gpio_level;
    else             txd_q <= line_bit ^ pol;
  end

  assign txd         = txd_q;
  assign buf_full    = full;
  assign shift_empty = ~busy & empty;
  assign brk_pending = brk_q;

  // R11: the pin follows the port level while disabled
  p_pin_released_r11: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (txd == $past(gpio_level)));

  // R4: an empty transmitter cannot report a full buffer
  p_empty_not_full_r4: assert property (@(posedge clk) disable iff (rst)
    shift_empty |-> !buf_full);

  // R9: a pending break is only dropped by its own completion or a disable
  p_brk_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (brk_pending && tx_en && !(done && brk_active)) |=> brk_pending);
endmodule

// File: tb/uart_tx_engine_test.sv
module uart_tx_engine_test;
  localparam int CLK_P = 10;
  localparam int DIV   = 8;

  logic       clk = 1'b0;
  logic       rst, tx_en, baud_tick, wr_valid, brk_set;
  logic [7:0] wr_data;
  logic [1:0] irq_mode;
  logic       idle_inv, ir_mode, gpio_level;
  logic       buf_full, shift_empty, brk_pending, irq, txd;

  int n_chk = 0, n_fail = 0, irq_cnt = 0, ph = 0;
  bit tick_on = 1'b1;
  int rx_q[$], exp_q[$];
  int mstate = 0, mcnt = 0, mlows = 0;
  logic [7:0] mbyte;

  uart_tx_engine uut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .baud_tick(baud_tick),
    .wr_valid(wr_valid), .wr_data(wr_data), .brk_set(brk_set),
    .irq_mode(irq_mode), .idle_inv(idle_inv), .ir_mode(ir_mode),
    .gpio_level(gpio_level), .buf_full(buf_full), .shift_empty(shift_empty),
    .brk_pending(brk_pending), .irq(irq), .txd(txd)
  );

  always #(CLK_P/2) clk = ~clk;

  // tick source, mid-bit line decoder and interrupt counter
  always @(negedge clk) begin
    int  cur;
    bit  b;
    cur = ph;
    if (!tx_en) mstate = 0;
    else if (cur == 4) begin
      b = txd ^ (idle_inv ^ ir_mode);
      case (mstate)
        0: if (!b) begin mstate = 1; mcnt = 0; mbyte = 8'h00; end
        1: begin
             mbyte[mcnt] = b;
             mcnt++;
             if (mcnt == 8) mstate = 2;
           end
        2: if (b) begin rx_q.push_back(int'(mbyte)); mstate = 0; end
           else if (mbyte == 8'h00) begin mstate = 3; mlows = 10; end
           else begin rx_q.push_back(2000); mstate = 0; end
        default: if (!b) mlows++;
                 else begin rx_q.push_back(1000 + mlows); mstate = 0; end
      endcase
    end
    ph = (ph == DIV - 1) ? 0 : ph + 1;
    baud_tick = tick_on && (cur == DIV - 1);
    if (irq) irq_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic align();
    do begin @(negedge clk); #1; end while (!baud_tick);
  endtask

  task automatic wait_empty();
    do @(negedge clk); while (!shift_empty);
    step(6);
  endtask

  task automatic compare_rx(input string tag);
    int n;
    chk(rx_q.size() == exp_q.size(), {tag, " count"}, rx_q.size(), exp_q.size());
    n = (rx_q.size() < exp_q.size()) ? rx_q.size() : exp_q.size();
    for (int i = 0; i < n; i++)
      chk(rx_q[i] == exp_q[i], {tag, " value"}, rx_q[i], exp_q[i]);
    rx_q.delete();
    exp_q.delete();
  endtask

  function automatic int exp_irqs(input int mode, input int n);
    case (mode)
      0:       return n;
      1, 2:    return 1;
      default: return 0;
    endcase
  endfunction

  task automatic burst(input int mode, input int n, input string tag);
    int base;
    logic [7:0] b;
    irq_mode = 2'(mode);
    align();
    base = irq_cnt;
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom_range(0, 255));
      exp_q.push_back(int'(b));
      wr(b);
    end
    wait_empty();
    compare_rx({tag, " R3 frames"});
    chk(irq_cnt - base == exp_irqs(mode, n), {tag, " irq count"}, irq_cnt - base, exp_irqs(mode, n));
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed_v, base;
    logic [7:0] b;
    seed_v = $urandom(32'h00C0FFEE);
    rst = 1'b1; tx_en = 1'b0; wr_valid = 1'b0; wr_data = 8'h00; brk_set = 1'b0;
    irq_mode = 2'b00; idle_inv = 1'b0; ir_mode = 1'b0; gpio_level = 1'b1;
    step(3);
    chk(buf_full == 1'b0, "R1 buf_full", buf_full, 0);
    chk(shift_empty == 1'b1, "R1 shift_empty", shift_empty, 1);
    chk(brk_pending == 1'b0, "R1 brk_pending", brk_pending, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(txd == 1'b1, "R1 txd", txd, 1);
    rst = 1'b0;

    // disabled pin and ignored writes
    gpio_level = 1'b0;
    step(2);
    chk(txd == 1'b0, "R11 pin follows gpio", txd, 0);
    wr(8'h5A);
    step(2);
    chk(shift_empty == 1'b1, "R11 write ignored while disabled", shift_empty, 1);
    gpio_level = 1'b1;
    tx_en = 1'b1;
    step(DIV * 12);
    chk(rx_q.size() == 0, "R11 nothing sent after disabled write", rx_q.size(), 0);
    chk(txd == 1'b1, "R10 idle high", txd, 1);

    burst(0, 3, "R5 mode00");
    burst(2, 4, "R6 mode10");
    burst(1, 3, "R7 mode01");
    burst(3, 2, "R8 mode11");

    // R4: busy shifter with empty buffer
    irq_mode = 2'b11;
    align();
    b = 8'($urandom_range(0, 255));
    exp_q.push_back(int'(b));
    wr(b);
    step(DIV + 2);
    chk(shift_empty == 1'b0, "R4 frame in flight", shift_empty, 0);
    chk(buf_full == 1'b0, "R4 buffer drained", buf_full, 0);
    wait_empty();
    chk(shift_empty == 1'b1, "R4 all done", shift_empty, 1);
    compare_rx("R4 single");

    // R2: stalled ticks, fill and overfill
    tick_on = 1'b0;
    step(DIV + 2);
    for (int i = 0; i < 4; i++) begin
      b = 8'($urandom_range(0, 255));
      exp_q.push_back(int'(b));
      wr(b);
      if (i == 2) chk(buf_full == 1'b0, "R2 three held", buf_full, 0);
    end
    chk(buf_full == 1'b1, "R2 four held", buf_full, 1);
    chk(shift_empty == 1'b0, "R4 queued", shift_empty, 0);
    wr(8'hE7);
    chk(buf_full == 1'b1, "R2 overfill", buf_full, 1);
    tick_on = 1'b1;
    wait_empty();
    compare_rx("R2 overfill dropped");

    // R9: break ahead of a queued character
    irq_mode = 2'b00;
    align();
    base = irq_cnt;
    b = 8'($urandom_range(1, 255));
    brk_set = 1'b1; wr_valid = 1'b1; wr_data = b;
    @(negedge clk);
    brk_set = 1'b0; wr_valid = 1'b0;
    chk(brk_pending == 1'b1, "R9 pending set", brk_pending, 1);
    exp_q.push_back(1000 + 1 + BRK_ZEROS_EXP());
    exp_q.push_back(int'(b));
    wait_empty();
    compare_rx("R9 break then byte");
    chk(brk_pending == 1'b0, "R9 pending cleared", brk_pending, 0);
    chk(irq_cnt - base == 1, "R9 break not a move", irq_cnt - base, 1);

    // R10: polarity combinations
    idle_inv = 1'b1;
    step(2);
    chk(txd == 1'b0, "R10 idle low", txd, 0);
    burst(0, 2, "R10 inverted");
    ir_mode = 1'b1;
    step(2);
    chk(txd == 1'b1, "R10 ir flips sense", txd, 1);
    burst(0, 1, "R10 ir both set");
    idle_inv = 1'b0;
    step(2);
    chk(txd == 1'b0, "R10 ir only", txd, 0);
    ir_mode = 1'b0;
    step(2);

    // R11: abort mid-frame with a break pending
    irq_mode = 2'b01;
    align();
    base = irq_cnt;
    for (int i = 0; i < 3; i++) wr(8'($urandom_range(0, 255)));
    step(20);
    brk_set = 1'b1;
    @(negedge clk);
    brk_set = 1'b0;
    chk(brk_pending == 1'b1, "R11 break queued", brk_pending, 1);
    gpio_level = 1'b0;
    tx_en = 1'b0;
    step(2);
    chk(txd == 1'b0, "R11 pin released", txd, 0);
    chk(shift_empty == 1'b1, "R11 flushed", shift_empty, 1);
    chk(buf_full == 1'b0, "R11 buffer reset", buf_full, 0);
    chk(brk_pending == 1'b0, "R11 break cancelled", brk_pending, 0);
    gpio_level = 1'b1;
    tx_en = 1'b1;
    step(300);
    chk(rx_q.size() == 0, "R11 nothing after re-enable", rx_q.size(), 0);
    chk(irq_cnt - base == 0, "R11 no completion irq", irq_cnt - base, 0);
    rx_q.delete();

    // random bursts across the three active modes
    for (int it = 0; it < 12; it++) begin
      int m;
      m = int'($urandom_range(0, 2));
      burst(m, int'($urandom_range(1, 4)), (m == 0) ? "R5 rand" : (m == 1) ? "R7 rand" : "R6 rand");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // zero data bits in a break frame, from R9
  function automatic int BRK_ZEROS_EXP();
    return 12;
  endfunction
endmodule